// File: doc/BRIEF.md
# Speculative Load Alias Tracker

This block lets a core move a load ahead of older stores that might write the same memory. When such an early ("advanced") load executes, the core records it in a small fully associative table. The table keeps the load's destination register index and the 8-byte-aligned part of its address. Every store that executes afterwards presents its address. Any table entry whose address falls in the same 8-byte block is cleared.

Where the load originally sat, the core issues a verification query for the destination register. The query names one of two follow-up forms:

- **Reload form:** if the entry is gone, the load is simply repeated.
- **Recover form:** if the entry is gone, control moves to recovery code.

Each query produces one result. The result reports hit or miss and an action code: use the value, reload, or branch to recovery. Allocation and store snoops are plain strobes that are accepted on every cycle. The query and its result form a valid/ready pair:

- A query is accepted when `chk_ready` is high, and `chk_ready` equals `!res_valid || res_ready`.
- A result stays on the outputs, unchanged, until `res_ready` takes it.

Top module: `spec_load_tracker`

## Requirements
- R1: After reset no entry is valid, `res_valid` is 0, and a query for any register reports a miss.
- R2: A query for a register with a valid entry, and no store to that entry's block in the same cycle, reports hit with action 0 (use the loaded value).
- R3: A store invalidates every valid entry whose address bits [63:3] equal the store's bits [63:3]. A reload-form query (`chk_branch`=0) that misses returns action 1 (reload).
- R4: A recover-form query (`chk_branch`=1) that misses returns action 2 (branch to recovery). When it hits, it returns action 0.
- R5: A store whose bits [63:3] differ from an entry's address leaves that entry valid. Address bits [2:0] of stores and allocations are ignored.
- R6: An allocation to a register that already has a valid entry overwrites that entry. From then on, only the new address is tracked for that register.
- R7: An allocation for a new register takes the lowest-numbered invalid entry. When all 16 entries are valid, it replaces the entry named by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping after entry 15, on each such replacement.
- R8: A store and an allocation in the same cycle are ordered store first. As a result, the newly written entry is valid even when both carry the same address.
- R9: A query is evaluated after the same-cycle store and before the same-cycle allocation. So a same-cycle matching store makes it miss, and a same-cycle allocation is not yet visible to it.
- R10: A query never changes the table. A hit leaves the entry in place, and a miss does not create one.
- R11: `chk_ready` equals `!res_valid || res_ready`. While `res_valid` is 1 and `res_ready` is 0, all result outputs hold their values.
- R12: An accepted query produces its result on the following cycle, with `res_reg` echoing the queried register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_en | input | 1 | Record an advanced load this cycle |
| alloc_reg | input | 7 | Destination register of the advanced load |
| alloc_addr | input | 64 | Byte address of the advanced load |
| st_en | input | 1 | A store executes this cycle |
| st_addr | input | 64 | Byte address of the store |
| chk_valid | input | 1 | Query request valid |
| chk_ready | output | 1 | Query can be accepted |
| chk_reg | input | 7 | Register whose advanced load is queried |
| chk_branch | input | 1 | 1 selects the recover form, 0 the reload form |
| res_valid | output | 1 | Query result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | 1 if the advanced load is still valid |
| res_action | output | 2 | 0 use value, 1 reload, 2 branch to recovery |
| res_reg | output | 7 | Register the result belongs to |

## Verification
The hardest state to reach from the ports is a full table in which the round-robin pointer has already moved. Reaching it takes sixteen distinct allocations with no intervening store hits, followed by further allocations to new registers. The only way to observe which entry was evicted is to query the previous owners afterwards. The bench fills the table deliberately, evicts twice, and probes the evicted and surviving registers. It then runs a long random phase that uses more registers than there are entries, so replacement, overwrite and invalidation keep interleaving. A behavioural model is compared with the outputs on every cycle.

// File: rtl/spec_tracker_pkg.sv
package spec_tracker_pkg;
  typedef enum logic [1:0] {
    ACT_USE     = 2'd0,
    ACT_RELOAD  = 2'd1,
    ACT_RECOVER = 2'd2
  } act_e;
endpackage

// File: rtl/spec_entry.sv
module spec_entry #(
  parameter int REG_W  = 7,
  parameter int ADDR_W = 64,
  parameter int OFS_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              vld,
  output logic              alloc_match,
  output logic              chk_match,
  output logic              st_match
);
  localparam int TAG_W = ADDR_W - OFS_W;

  logic [REG_W-1:0] reg_q;
  logic [TAG_W-1:0] tag_q;

  assign st_match    = vld && (tag_q == st_addr[ADDR_W-1:OFS_W]);
  assign alloc_match = vld && (reg_q == alloc_reg);
  assign chk_match   = vld && (reg_q == chk_reg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= 1'b0;
      reg_q <= '0;
      tag_q <= '0;
    end else if (wr_en) begin
      vld   <= 1'b1;
      reg_q <= wr_reg;
      tag_q <= wr_addr[ADDR_W-1:OFS_W];
    end else if (st_en && st_match) begin
      vld <= 1'b0;
    end
  end
endmodule

// File: rtl/spec_victim.sv
module spec_victim #(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_en,
  input  logic [ENTRIES-1:0] vld_vec,
  input  logic [ENTRIES-1:0] reg_hit_vec,
  output logic [ENTRIES-1:0] sel
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] idx;
  logic             use_ptr;

  always_comb begin
    idx     = ptr_q;
    use_ptr = 1'b0;
    if (|reg_hit_vec) begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (reg_hit_vec[i]) idx = IDX_W'(i);
    end else if (!(&vld_vec)) begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!vld_vec[i]) idx = IDX_W'(i);
    end else begin
      use_ptr = 1'b1;
    end
    sel      = '0;
    sel[idx] = alloc_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (alloc_en && use_ptr) begin
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/spec_result.sv
module spec_result #(
  parameter int REG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             hit,
  input  logic             branch_form,
  input  logic [REG_W-1:0] q_reg,
  input  logic             res_ready,
  output logic             res_valid,
  output logic             res_hit,
  output logic [1:0]       res_action,
  output logic [REG_W-1:0] res_reg
);
  import spec_tracker_pkg::*;

  act_e act_d;

  always_comb begin
    if (hit)              act_d = ACT_USE;
    else if (branch_form) act_d = ACT_RECOVER;
    else                  act_d = ACT_RELOAD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_action <= 2'd0;
      res_reg    <= '0;
    end else if (accept) begin
      res_valid  <= 1'b1;
      res_hit    <= hit;
      res_action <= act_d;
      res_reg    <= q_reg;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker #(
  parameter int ENTRIES = 16,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 64,
  parameter int OFS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              chk_valid,
  output logic              chk_ready,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_branch,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [1:0]        res_action,
  output logic [REG_W-1:0]  res_reg
);
  logic [ENTRIES-1:0] vld_vec;
  logic [ENTRIES-1:0] alloc_match_vec;
  logic [ENTRIES-1:0] chk_match_vec;
  logic [ENTRIES-1:0] st_match_vec;
  logic [ENTRIES-1:0] alloc_sel;
  logic               lookup_hit;
  logic               accept;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    spec_entry #(.REG_W(REG_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ent (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (alloc_sel[g]),
      .wr_reg      (alloc_reg),
      .wr_addr     (alloc_addr),
      .st_en       (st_en),
      .st_addr     (st_addr),
      .alloc_reg   (alloc_reg),
      .chk_reg     (chk_reg),
      .vld         (vld_vec[g]),
      .alloc_match (alloc_match_vec[g]),
      .chk_match   (chk_match_vec[g]),
      .st_match    (st_match_vec[g])
    );
  end

  spec_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_en    (alloc_en),
    .vld_vec     (vld_vec),
    .reg_hit_vec (alloc_match_vec),
    .sel         (alloc_sel)
  );

  assign lookup_hit = |(chk_match_vec & ~(st_en ? st_match_vec : '0));
  assign chk_ready  = !res_valid || res_ready;
  assign accept     = chk_valid && chk_ready;

  spec_result #(.REG_W(REG_W)) u_result (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .hit         (lookup_hit),
    .branch_form (chk_branch),
    .q_reg       (chk_reg),
    .res_ready   (res_ready),
    .res_valid   (res_valid),
    .res_hit     (res_hit),
    .res_action  (res_action),
    .res_reg     (res_reg)
  );
endmodule

// File: rtl/spec_tracker_chk.sv
module spec_tracker_chk #(
  parameter int ENTRIES = 16,
  parameter int REG_W   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               alloc_en,
  input logic               chk_valid,
  input logic               chk_ready,
  input logic               res_valid,
  input logic               res_ready,
  input logic               res_hit,
  input logic [1:0]         res_action,
  input logic [REG_W-1:0]   res_reg,
  input logic [ENTRIES-1:0] chk_match_vec,
  input logic [ENTRIES-1:0] alloc_sel
);
  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_hit) &&
                                $stable(res_action) && $stable(res_reg));

  // R12
  res_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_ready |=> res_valid);

  // R6
  one_entry_per_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chk_match_vec));

  // R7
  single_slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> $onehot(alloc_sel));

  // R4
  action_matches_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit == (res_action == 2'd0)) && (res_action != 2'd3));
endmodule

bind spec_load_tracker spec_tracker_chk #(.ENTRIES(ENTRIES), .REG_W(REG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .alloc_en      (alloc_en),
  .chk_valid     (chk_valid),
  .chk_ready     (chk_ready),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_hit       (res_hit),
  .res_action    (res_action),
  .res_reg       (res_reg),
  .chk_match_vec (chk_match_vec),
  .alloc_sel     (alloc_sel)
);

// File: tb/tb_spec_load_tracker.sv
`timescale 1ns/1ps
module tb_spec_load_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_en = 0, st_en = 0, chk_valid = 0, chk_branch = 0, res_ready = 1;
  logic [6:0]  alloc_reg = 0, chk_reg = 0;
  logic [63:0] alloc_addr = 0, st_addr = 0;
  logic        chk_ready, res_valid, res_hit;
  logic [1:0]  res_action;
  logic [6:0]  res_reg;

  int checks = 0, errors = 0;
  string phase = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  spec_load_tracker dut (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_reg(alloc_reg),
    .alloc_addr(alloc_addr), .st_en(st_en), .st_addr(st_addr),
    .chk_valid(chk_valid), .chk_ready(chk_ready), .chk_reg(chk_reg),
    .chk_branch(chk_branch), .res_valid(res_valid), .res_ready(res_ready),
    .res_hit(res_hit), .res_action(res_action), .res_reg(res_reg)
  );

  // behavioural reference
  bit        m_v[16];
  int        m_r[16];
  longint unsigned m_a[16];
  int        m_ptr;
  bit        m_rv, m_hit;
  int        m_act, m_reg;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_ptr = 0; m_rv = 0; m_hit = 0; m_act = 0; m_reg = 0;
    end else begin
      bit pv[16];
      bit acc, hit;
      int slot;
      slot = -1;
      pv = m_v;
      acc = chk_valid && (!m_rv || res_ready);
      hit = 0;
      foreach (m_v[i])
        if (pv[i] && m_r[i] == int'(chk_reg) && !(st_en && m_a[i] == (st_addr >> 3))) hit = 1;
      if (alloc_en) begin
        foreach (m_v[i]) if (slot < 0 && pv[i] && m_r[i] == int'(alloc_reg)) slot = i;
        foreach (m_v[i]) if (slot < 0 && !pv[i]) slot = i;
        if (slot < 0) begin slot = m_ptr; m_ptr = (m_ptr + 1) % 16; end
      end
      if (acc) begin
        m_rv = 1; m_hit = hit; m_reg = int'(chk_reg);
        m_act = hit ? 0 : (chk_branch ? 2 : 1);
      end else if (res_ready) m_rv = 0;
      if (st_en) foreach (m_v[i]) if (pv[i] && m_a[i] == (st_addr >> 3)) m_v[i] = 0;
      if (slot >= 0) begin
        m_v[slot] = 1; m_r[slot] = int'(alloc_reg); m_a[slot] = alloc_addr >> 3;
      end
    end
  end

  task automatic chk1(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk1("res_valid", res_valid, m_rv);
      chk1("chk_ready", chk_ready, (!m_rv || res_ready));
      if (m_rv) begin
        chk1("res_hit", res_hit, m_hit);
        chk1("res_action", res_action, m_act);
        chk1("res_reg", res_reg, m_reg);
      end
    end
  end

  task automatic cyc(bit a, int ar, longint unsigned aa, bit s, longint unsigned sa,
                     bit c, int cr, bit br, bit rr = 1);
    @(negedge clk);
    alloc_en = a; alloc_reg = 7'(ar); alloc_addr = aa;
    st_en = s; st_addr = sa;
    chk_valid = c; chk_reg = 7'(cr); chk_branch = br; res_ready = rr;
  endtask

  task automatic idle(); cyc(0,0,0,0,0,0,0,0); endtask
  task automatic alloc(int r, longint unsigned a); cyc(1,r,a,0,0,0,0,0); endtask
  task automatic store(longint unsigned a); cyc(0,0,0,1,a,0,0,0); endtask
  task automatic query(int r, bit br); cyc(0,0,0,0,0,1,r,br); endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    alloc_en = 0; st_en = 0; chk_valid = 0; res_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired in %s", phase);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    phase = "R1"; idle(); query(5, 0); query(0, 1); idle();
    phase = "R2"; alloc(3, 64'h1000); query(3, 0); idle();
    phase = "R3"; alloc(4, 64'h2000); store(64'h2005); query(4, 0); idle();
    phase = "R4"; query(4, 1); alloc(6, 64'h3000); query(6, 1); idle();
    phase = "R5"; alloc(7, 64'h4003); store(64'h4008); store(64'h3ff8); query(7, 0);
    store(64'h4007); query(7, 0); idle();
    phase = "R6"; alloc(8, 64'h5000); alloc(8, 64'h6000); store(64'h5000); query(8, 0);
    store(64'h6000); query(8, 0); idle();
    phase = "R8"; cyc(1, 9, 64'h7000, 1, 64'h7000, 0, 0, 0); query(9, 0); idle();
    phase = "R9"; alloc(11, 64'h8000); cyc(0, 0, 0, 1, 64'h8000, 1, 11, 1);
    cyc(1, 12, 64'h9000, 0, 0, 1, 12, 0); query(12, 0); idle();
    phase = "R10"; query(12, 0); query(12, 0); query(13, 0); query(13, 0); idle();
    phase = "R11"; cyc(0,0,0,0,0,1,12,0,0); cyc(0,0,0,0,0,1,3,1,0); cyc(0,0,0,0,0,1,3,1,0);
    cyc(0,0,0,0,0,1,3,1,1); cyc(0,0,0,0,0,1,4,1,0); idle(); idle();
    phase = "R7"; do_reset();
    for (int i = 0; i < 16; i++) alloc(10 + i, 64'h10000 + 64'(i) * 8);
    alloc(40, 64'h20000); alloc(41, 64'h20008);
    query(10, 0); query(11, 0); query(12, 0); query(40, 0); query(41, 0); query(25, 0);
    store(64'h10018); alloc(42, 64'h20010); query(13, 0); query(42, 0); query(14, 0);
    alloc(43, 64'h20018); query(14, 0); idle();
    phase = "R12"; do_reset();
    for (int n = 0; n < 4000; n++) begin
      int pick;
      pick = $urandom_range(0, 9);
      cyc($urandom_range(0, 2) == 0, $urandom_range(0, 21),
          64'h400 + 64'($urandom_range(0, 5)) * 8 + 64'($urandom_range(0, 7)),
          $urandom_range(0, 3) == 0,
          64'h400 + 64'($urandom_range(0, 5)) * 8 + 64'($urandom_range(0, 7)),
          pick < 6, $urandom_range(0, 21), $urandom_range(0, 1),
          $urandom_range(0, 3) != 0);
    end
    idle(); idle();
    @(negedge clk); #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule